// File: doc/BRIEF.md
# Four-Point Distributed-Arithmetic Inner Product

This block forms the signed dot product of four weights with the four most recent input samples, and it uses no multiplier. Each time a sample is strobed in, a bank of fifteen registers is refreshed so that it holds every nonzero subset sum of the four newest samples. A computation then takes one bit position of all four weights per clock, least significant position first. Those four bits address the bank, and the value read out is folded into a carry-save sum/carry register pair. Because the carry-save step has no carry chain, each clock costs only a table read and one full-adder level.

The most significant bit position carries negative weight in two's complement. Its table value is therefore inverted bit by bit, and the missing one is supplied as the carry-in of the single merging adder at the end. The bank is refilled with seven adders working in parallel: half of the new entries are copies of old entries, and the other half are old entries plus the incoming sample.

A start pulse captures the four weights. The result and a one-cycle done pulse appear a fixed number of clocks later. A new start can be accepted in the same clock in which the previous result is being merged, so computations can run back to back.

Top module: `da4_dot_product`

## Requirements
- R1: Samples form a four-deep history. Tap x0 is the newest and x3 the oldest. Every cycle with `sampleValid` high shifts the history by one, with `sampleIn` entering as x0.
- R2: In slice cycle l, the table address is {weight3[l], weight2[l], weight1[l], weight0[l]}, with weight0's bit as address bit 0. Table entry k is the sum of the taps x_j for which bit j of k is one, so address zero contributes zero. Slices are consumed from bit 0 upward, one per cycle.
- R3: `result` is the exact two's-complement value of w0·x0 + w1·x1 + w2·x2 + w3·x3, SAMPLE_W+WEIGHT_W+2 bits wide. Weights and samples are signed, and this includes the case where every operand is the most negative value.
- R4: `start` is accepted at a rising edge where no computation is active. The weights are captured at that same edge. `done` is high in the cycle that follows the (WEIGHT_W+1)-th rising edge after the accepting edge.
- R5: `done` is high for exactly one cycle per accepted start.
- R6: A `start`, or a change on the weight inputs, during the WEIGHT_W cycles after acceptance is ignored. It affects neither the result nor the done timing.
- R7: A `start` sampled at the edge where the previous result is merged is accepted. The previous result and its done pulse come out unchanged, and the new computation completes WEIGHT_W+1 edges later.
- R8: `result` keeps its value from one done pulse until the next.
- R9: A sample strobed at the same edge that accepts a start is part of the history used by that computation.
- R10: After reset, `done` and `result` are zero and all four taps read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Shift `sampleIn` into the sample history |
| sampleIn | input | SAMPLE_W | New signed sample |
| weight0 | input | WEIGHT_W | Signed weight of tap x0 |
| weight1 | input | WEIGHT_W | Signed weight of tap x1 |
| weight2 | input | WEIGHT_W | Signed weight of tap x2 |
| weight3 | input | WEIGHT_W | Signed weight of tap x3 |
| start | input | 1 | Begin a computation when idle |
| result | output | SAMPLE_W+WEIGHT_W+2 | Signed inner product |
| done | output | 1 | One-cycle pulse when `result` is new |

## Verification
Two functions can coincide in a single cycle.

The first is a start arriving in the clock where the previous sum and carry words are merged into `result`. The bench asserts start in the cycle right after the last slice edge. It then requires two things: the earlier result with its done pulse must come out untouched, and the new weights must produce their own correct result WEIGHT_W+1 edges later.

The second is a sample strobe landing on the edge that accepts a start. Here the bench expects the freshly shifted history in the product.

Both cases are judged against a reference multiply-accumulate computed from the bench's own copy of the sample history.

// File: rtl/da4_pkg.sv
package da4_pkg;

  // Fixed tap count of the distributed-arithmetic table.
  localparam int unsigned NUM_TAPS  = 4;
  localparam int unsigned TBL_DEPTH = 1 << NUM_TAPS;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic clearAcc;   // accepted start: load weights, zero the accumulator
    logic stepEn;     // accumulate one weight bit slice
    logic lastSlice;  // current slice is the sign slice
    logic finalize;   // merge sum and carry words into the result
  } daStrobes_t;

endpackage

// File: rtl/da4_subset_table.sv
module da4_subset_table
  import da4_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  localparam int ENTRY_W = SAMPLE_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [NUM_TAPS-1:0] addr,
  output logic [ENTRY_W-1:0]  selVal
);

  localparam int HALF = TBL_DEPTH / 2;

  // Entry k holds the sum of the taps selected by the one-bits of k.
  logic [ENTRY_W-1:0] entry [TBL_DEPTH];
  logic [ENTRY_W-1:0] sampleExt;

  assign sampleExt = {{(ENTRY_W-SAMPLE_W){sampleIn[SAMPLE_W-1]}}, sampleIn};

  // After a shift the old tap j becomes tap j+1. An even entry 2m is then
  // old entry m, and an odd entry 2m+1 is the new sample plus old entry m.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TBL_DEPTH; k++) entry[k] <= '0;
    end else if (sampleValid) begin
      entry[1] <= sampleExt;
      for (int m = 1; m < HALF; m++) begin
        entry[2*m]   <= entry[m];
        entry[2*m+1] <= sampleExt + entry[m];
      end
    end
  end

  // 16:1 selection; address zero reads as zero.
  always_comb begin
    selVal = '0;
    for (int k = 1; k < TBL_DEPTH; k++) begin
      if (addr == NUM_TAPS'(k)) selVal = entry[k];
    end
  end

  // R1: the all-taps entry must equal the sum of the single-tap entries.
  p_subset_sum_r1: assert property (@(posedge clk) disable iff (!rstN)
    entry[TBL_DEPTH-1] == entry[1] + entry[2] + entry[4] + entry[8])
    else $error("table entries inconsistent");

endmodule

// File: rtl/da4_ctrl.sv
module da4_ctrl
  import da4_pkg::*;
#(
  parameter int WEIGHT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output daStrobes_t strobes,
  output logic       done
);

  localparam int CNT_W = (WEIGHT_W > 1) ? $clog2(WEIGHT_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WEIGHT_W - 1);

  logic             busy;
  logic [CNT_W-1:0] sliceIdx;
  logic             finPending;
  logic             accept;
  logic             isLast;

  assign accept = start && !busy;
  assign isLast = busy && (sliceIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      sliceIdx   <= '0;
      finPending <= 1'b0;
      done       <= 1'b0;
    end else begin
      done       <= finPending;
      finPending <= isLast;
      if (accept) begin
        busy     <= 1'b1;
        sliceIdx <= '0;
      end else if (busy) begin
        if (isLast) busy <= 1'b0;
        else        sliceIdx <= sliceIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.clearAcc  = accept;
    strobes.stepEn    = busy;
    strobes.lastSlice = isLast;
    strobes.finalize  = finPending;
  end

  // R4: an idle start begins at slice zero.
  p_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy && (sliceIdx == '0))
    else $error("start not accepted");

  // R6: mid-run slices advance by one regardless of start.
  p_busy_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy && !isLast |=> busy && (sliceIdx == $past(sliceIdx) + 1'b1))
    else $error("slice sequence disturbed");

  // R4: done follows the end of the slice run.
  p_done_after_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |=> done)
    else $error("done missing after run");

  // R5: single-cycle done pulse.
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done)
    else $error("done held too long");

endmodule

// File: rtl/da4_csa_datapath.sv
module da4_csa_datapath
  import da4_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int WEIGHT_W = 8,
  localparam int ENTRY_W = SAMPLE_W + 2,
  localparam int RES_W   = SAMPLE_W + WEIGHT_W + 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  daStrobes_t                         strobes,
  input  logic [NUM_TAPS-1:0][WEIGHT_W-1:0]  weightsIn,
  input  logic [ENTRY_W-1:0]                 selVal,
  output logic [NUM_TAPS-1:0]                sliceAddr,
  output logic [RES_W-1:0]                   result
);

  localparam int ACC_W  = ENTRY_W + 1;
  localparam int LOW_W  = WEIGHT_W - 1;
  localparam int FULL_W = ACC_W + 1 + LOW_W;
  localparam logic [ENTRY_W-1:0] SIGN_FLIP = ENTRY_W'(1) << (ENTRY_W - 1);
  // Offset removed at the end: each slice added 2^(ENTRY_W-1) at weight 2^l.
  localparam logic [FULL_W-1:0] OFFSET_FULL =
    FULL_W'((2 ** WEIGHT_W) - 1) << (ENTRY_W - 1);
  localparam logic [RES_W-1:0] OFFSET_RES = RES_W'(OFFSET_FULL);

  logic [NUM_TAPS-1:0][WEIGHT_W-1:0] wShift;
  logic [ACC_W-1:0]   sumW;
  logic [ACC_W-1:0]   carryW;
  logic [LOW_W-1:0]   lowBits;
  logic [ENTRY_W-1:0] qFlip;
  logic [ACC_W-1:0]   qExt;
  logic [ACC_W-1:0]   csSum;
  logic [ACC_W-2:0]   csMaj;
  logic [WEIGHT_W-1:0] lowCat;
  logic [ACC_W:0]     mergedHigh;
  logic [RES_W-1:0]   resVal;

  // Bit slice address: bit 0 of each shifting weight.
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_addr
    assign sliceAddr[k] = wShift[k][0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wShift <= '0;
    end else if (strobes.clearAcc) begin
      wShift <= weightsIn;
    end else if (strobes.stepEn) begin
      for (int k = 0; k < NUM_TAPS; k++) wShift[k] <= wShift[k] >> 1;
    end
  end

  // Sign control inverts the sign slice. The sign-bit flip makes every
  // addend non-negative, so the right-shifted words never lose a carry.
  assign qFlip = selVal ^ {ENTRY_W{strobes.lastSlice}} ^ SIGN_FLIP;
  assign qExt  = {1'b0, qFlip};
  assign csSum = sumW ^ carryW ^ qExt;
  assign csMaj = (sumW[ACC_W-2:0] & carryW[ACC_W-2:0])
               | (sumW[ACC_W-2:0] & qExt[ACC_W-2:0])
               | (carryW[ACC_W-2:0] & qExt[ACC_W-2:0]);
  assign lowCat = {csSum[0], lowBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumW    <= '0;
      carryW  <= '0;
      lowBits <= '0;
    end else if (strobes.clearAcc) begin
      sumW    <= '0;
      carryW  <= '0;
      lowBits <= '0;
    end else if (strobes.stepEn) begin
      if (strobes.lastSlice) begin
        sumW   <= csSum;
        carryW <= {csMaj, 1'b0};
      end else begin
        // Bit 0 of the carry word is zero, so csSum[0] is a final bit.
        sumW    <= csSum >> 1;
        carryW  <= {1'b0, csMaj};
        lowBits <= lowCat[WEIGHT_W-1:1];
      end
    end
  end

  // Final merge with carry-in one completes the sign-slice negation.
  assign mergedHigh = {1'b0, sumW} + {1'b0, carryW} + (ACC_W+1)'(1);
  assign resVal     = RES_W'({mergedHigh, lowBits}) - OFFSET_RES;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 result <= '0;
    else if (strobes.finalize) result <= resVal;
  end

  // R8: result only moves on a merge.
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finalize |=> $stable(result))
    else $error("result changed outside merge");

endmodule

// File: rtl/da4_dot_product.sv
module da4_dot_product
  import da4_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int WEIGHT_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sampleValid,
  input  logic [SAMPLE_W-1:0]              sampleIn,
  input  logic [WEIGHT_W-1:0]              weight0,
  input  logic [WEIGHT_W-1:0]              weight1,
  input  logic [WEIGHT_W-1:0]              weight2,
  input  logic [WEIGHT_W-1:0]              weight3,
  input  logic                             start,
  output logic [SAMPLE_W+WEIGHT_W+1:0]     result,
  output logic                             done
);

  localparam int ENTRY_W = SAMPLE_W + 2;

  daStrobes_t                        strobes;
  logic [NUM_TAPS-1:0]               sliceAddr;
  logic [ENTRY_W-1:0]                selVal;
  logic [NUM_TAPS-1:0][WEIGHT_W-1:0] weightsPacked;

  assign weightsPacked = {weight3, weight2, weight1, weight0};

  da4_ctrl #(.WEIGHT_W(WEIGHT_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  da4_subset_table #(.SAMPLE_W(SAMPLE_W)) table_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleIn    (sampleIn),
    .addr        (sliceAddr),
    .selVal      (selVal)
  );

  da4_csa_datapath #(.SAMPLE_W(SAMPLE_W), .WEIGHT_W(WEIGHT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .weightsIn (weightsPacked),
    .selVal    (selVal),
    .sliceAddr (sliceAddr),
    .result    (result)
  );

endmodule

// File: tb/da4_dot_product_tb_top.sv
`timescale 1ns/1ps
module da4_dot_product_tb_top;

  localparam int SAMPLE_W = 8;
  localparam int WEIGHT_W = 8;
  localparam int RES_W    = SAMPLE_W + WEIGHT_W + 2;

  logic                clk = 1'b0;
  logic                rstN;
  logic                sampleValid;
  logic [SAMPLE_W-1:0] sampleIn;
  logic [WEIGHT_W-1:0] wIn [4];
  logic                start;
  logic [RES_W-1:0]    result;
  logic                done;

  int testsRun    = 0;
  int testsFailed = 0;
  bit finished    = 0;
  longint modelX [4];

  always #4 clk = ~clk;

  da4_dot_product #(.SAMPLE_W(SAMPLE_W), .WEIGHT_W(WEIGHT_W)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .weight0(wIn[0]), .weight1(wIn[1]), .weight2(wIn[2]), .weight3(wIn[3]),
    .start(start), .result(result), .done(done)
  );

  function automatic longint sextS(logic [SAMPLE_W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint sextW(logic [WEIGHT_W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint expectedDot();
    longint acc = 0;
    for (int k = 0; k < 4; k++) acc += sextW(wIn[k]) * modelX[k];
    return acc;
  endfunction

  function automatic longint resSigned();
    return longint'($signed(result));
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic shiftModel(logic [SAMPLE_W-1:0] v);
    for (int k = 3; k > 0; k--) modelX[k] = modelX[k-1];
    modelX[0] = sextS(v);
  endtask

  task automatic pushSample(logic [SAMPLE_W-1:0] v);
    sampleValid = 1'b1;
    sampleIn    = v;
    @(posedge clk);
    shiftModel(v);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic setWeights(logic [WEIGHT_W-1:0] a, logic [WEIGHT_W-1:0] b,
                            logic [WEIGHT_W-1:0] c, logic [WEIGHT_W-1:0] d);
    wIn[0] = a; wIn[1] = b; wIn[2] = c; wIn[3] = d;
  endtask

  // Starts at a negedge with weights already set; ends at a negedge.
  task automatic runOp(string req, bit withSample, logic [SAMPLE_W-1:0] sv, bit poke);
    longint exp;
    bit early = 0;
    start = 1'b1;
    if (withSample) begin sampleValid = 1'b1; sampleIn = sv; end
    @(posedge clk);
    if (withSample) shiftModel(sv);
    exp = expectedDot();
    @(negedge clk);
    start = 1'b0;
    sampleValid = 1'b0;
    for (int i = 1; i <= WEIGHT_W + 1; i++) begin
      if (poke && i == 2) begin
        start = 1'b1;
        for (int k = 0; k < 4; k++) wIn[k] = WEIGHT_W'($urandom());
      end
      @(posedge clk);
      @(negedge clk);
      if (poke && i == 2) start = 1'b0;
      if (i <= WEIGHT_W && done) early = 1;
    end
    check(req, "no early done", longint'(early), 0);
    check(req, "done at expected cycle", longint'(done), 1);
    check(req, "result value", resSigned(), exp);
    @(posedge clk);
    @(negedge clk);
    check("R5", "done single cycle", longint'(done), 0);
    check("R8", "result held", resSigned(), exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    longint expA;
    longint expB;
    void'($urandom(32'd48611));
    for (int k = 0; k < 4; k++) modelX[k] = 0;
    rstN = 1'b0; sampleValid = 1'b0; sampleIn = '0; start = 1'b0;
    setWeights('0, '0, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "done in reset", longint'(done), 0);
    check("R10", "result in reset", resSigned(), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R10: taps are zero after reset.
    setWeights(8'd37, 8'd200, 8'd5, 8'd128);
    runOp("R10", 1'b0, '0, 1'b0);

    // R1: one-hot weights pick out each tap in history order.
    pushSample(8'd5);
    pushSample(8'hFD);
    pushSample(8'd127);
    pushSample(8'h80);
    for (int j = 0; j < 4; j++) begin
      setWeights('0, '0, '0, '0);
      wIn[j] = 8'd1;
      runOp("R1", 1'b0, '0, 1'b0);
    end

    // R2: all-zero slices read zero from the table.
    setWeights('0, '0, '0, '0);
    runOp("R2", 1'b0, '0, 1'b0);
    // R2: only the sign slice is set.
    setWeights(8'h80, 8'h80, 8'h80, 8'h80);
    runOp("R2", 1'b0, '0, 1'b0);

    // R3: extreme operands.
    for (int k = 0; k < 4; k++) pushSample(8'h80);
    setWeights(8'h80, 8'h80, 8'h80, 8'h80);
    runOp("R3", 1'b0, '0, 1'b0);
    setWeights(8'h7F, 8'h7F, 8'h7F, 8'h7F);
    runOp("R3", 1'b0, '0, 1'b0);
    for (int k = 0; k < 4; k++) pushSample(8'h7F);
    runOp("R3", 1'b0, '0, 1'b0);
    setWeights(8'hFF, 8'h01, 8'hFF, 8'h80);
    runOp("R3", 1'b0, '0, 1'b0);

    // R6: start and weight changes mid-run are ignored.
    pushSample(8'd19);
    setWeights(8'd3, 8'hF0, 8'd77, 8'h9C);
    runOp("R6", 1'b0, '0, 1'b1);

    // R9: sample strobe on the accepting edge.
    setWeights(8'd11, 8'hE2, 8'd64, 8'h05);
    runOp("R9", 1'b1, 8'hA5, 1'b0);

    // R7: start on the merge edge of the previous run.
    setWeights(8'd90, 8'hC3, 8'd2, 8'h71);
    start = 1'b1;
    @(posedge clk);
    expA = expectedDot();
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= WEIGHT_W; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    setWeights(8'h88, 8'd45, 8'hFE, 8'd120);
    start = 1'b1;
    @(posedge clk);
    expB = expectedDot();
    @(negedge clk);
    start = 1'b0;
    check("R7", "first done on merge edge", longint'(done), 1);
    check("R7", "first result intact", resSigned(), expA);
    for (int i = 1; i <= WEIGHT_W + 1; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    check("R7", "second done", longint'(done), 1);
    check("R7", "second result", resSigned(), expB);
    @(negedge clk);

    // R3 and R4: random histories and weights.
    for (int n = 0; n < 40; n++) begin
      int pushes;
      pushes = int'($urandom_range(0, 2));
      for (int p = 0; p < pushes; p++) pushSample(SAMPLE_W'($urandom()));
      for (int k = 0; k < 4; k++) wIn[k] = WEIGHT_W'($urandom());
      runOp("R4", bit'($urandom_range(0, 1)), SAMPLE_W'($urandom()),
            bit'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule